// File: doc/BRIEF.md
# CAN Command Decoder and Buffer Control

This block sits between the register bus of a CAN controller and its transmit and receive engines. Software drives a single write-only command byte. Each write can do several things at once: queue a transmission, queue a transmission that the node also receives itself, cancel a queued transmission, free the oldest received frame, or clear the overrun flag. Reads of the command register always return zero.

Three transmit buffers each carry a pending flag. Bits 7:5 of the command byte select buffers 2..0. A transmit request that selects several buffers marks exactly one of them. The choice follows a priority rule that software picks: either the lowest buffer number, or the lowest frame identifier with ties going to the lower buffer number. Whenever the transmit engine is idle, the same rule picks which pending buffer to launch next.

The receive side counts the frames held for software. From that count it derives the receive-buffer-status flag. It raises a sticky overrun flag when a frame arrives and there is no room for it.

Top module: `can_cmd_ctrl`

## Requirements
- R1: `reg_rdata` is always zero. After reset, `tx_pend` is 0, `rx_full_flag`, `rx_overrun` and `cmd_err` are 0, `rx_enable` is 1 and `tx_start` is 0.
- R2: A write strobe in the cycle right after another write strobe is dropped with no effect, and it sets `cmd_err`. `cmd_err` stays set until reset.
- R3: Bit 0 (transmit) marks one of the buffers selected by bits 5, 6 and 7 (buffers 0, 1 and 2) as pending. With no select bit set, the write changes nothing.
- R4: With `prio_by_id`=0, the chosen buffer is the lowest-numbered selected buffer.
- R5: With `prio_by_id`=1, the chosen buffer is the selected one with the smallest `slot_id` field (buffer k at bits k*11 +: 11). On a tie the lower buffer number wins.
- R6: The block raises `tx_start` for one cycle when three things hold: a buffer is pending, `tx_busy` is 0 and no buffer is in flight. At that point `tx_slot` names the buffer chosen by the same rule over the pending set. `tx_done` ends the flight and clears that buffer's pending flag.
- R7: Bit 1 (abort) clears the pending flag of each selected buffer that is not in flight. An in-flight buffer stays pending.
- R8: Bit 4 (self-reception) queues like bit 0, but `tx_self` is 1 at launch and `rx_enable` stays 1 during the flight. A plain transmission drives `rx_enable` to 0 while it is in flight.
- R9: Each `rx_frame` pulse adds a held frame (up to 2). Bit 2 (release) drops one held frame. `rx_full_flag` is 1 whenever any frame is held, so it clears only when the last frame is released.
- R10: A frame that arrives while 2 frames are held, with no release in the same cycle, sets `rx_overrun` and is discarded. A release in the same cycle lets the frame in.
- R11: Bit 3 clears `rx_overrun`. An overrun in the same cycle keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Command register write strobe |
| reg_wdata | input | 8 | Command byte |
| reg_rdata | output | 8 | Read data of the command register, always zero |
| prio_by_id | input | 1 | 1: identifier priority, 0: buffer-number priority |
| slot_id | input | 33 | Frame identifiers of buffers 2..0, 11 bits each |
| tx_busy | input | 1 | Transmit engine is busy |
| tx_done | input | 1 | Transmit engine finished the in-flight frame |
| tx_start | output | 1 | Launch pulse to the transmit engine |
| tx_slot | output | 2 | Buffer launched with `tx_start` |
| tx_self | output | 1 | Launched frame is a self-reception frame |
| tx_pend | output | 3 | Pending flag per transmit buffer |
| rx_enable | output | 1 | Receiver may take frames |
| rx_frame | input | 1 | Receive engine delivered a frame |
| rx_full_flag | output | 1 | At least one received frame is held |
| rx_overrun | output | 1 | Sticky overrun flag |
| cmd_err | output | 1 | Sticky flag for a write dropped by the spacing rule |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a release command and a frame arriving on a full store. The second is a clear-overrun command and a new overrun. The bench fills the store to two frames, then pulses `rx_frame` in the very cycle the command write is strobed. It judges the outcome only through `rx_overrun` and `rx_full_flag`: the release must let the frame in without an overrun, and the clear must lose against the overrun. A later pair of releases then shows the store still held two frames.

// File: rtl/can_cmd_pkg.sv
`timescale 1ns/1ps
package can_cmd_pkg;
  localparam int CMD_TX   = 0;
  localparam int CMD_ABT  = 1;
  localparam int CMD_REL  = 2;
  localparam int CMD_CLR  = 3;
  localparam int CMD_SELF = 4;
  localparam int SEL_LSB  = 5;

  typedef struct packed {
    logic tx;
    logic abt;
    logic rel;
    logic clr;
    logic self_rx;
  } cmd_t;
endpackage

// File: rtl/can_cmd_decode.sv
`timescale 1ns/1ps
module can_cmd_decode
  import can_cmd_pkg::*;
#(
  parameter int NBUF  = 3,
  localparam int CMD_W = SEL_LSB + NBUF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CMD_W-1:0] wdata,
  output cmd_t             cmd,
  output logic [NBUF-1:0]  sel,
  output logic             err
);
  logic wr_q;
  logic accept;
  logic too_close;

  assign too_close = wr && wr_q;
  assign accept    = wr && !wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      err  <= 1'b0;
    end else begin
      wr_q <= wr;
      if (too_close) err <= 1'b1;
    end
  end

  always_comb begin
    cmd.tx      = accept && wdata[CMD_TX];
    cmd.abt     = accept && wdata[CMD_ABT];
    cmd.rel     = accept && wdata[CMD_REL];
    cmd.clr     = accept && wdata[CMD_CLR];
    cmd.self_rx = accept && wdata[CMD_SELF];
    sel         = wdata[SEL_LSB +: NBUF];
  end

  AST_GAP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr && $past(wr) |=> err); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R2
endmodule

// File: rtl/can_tx_pick.sv
`timescale 1ns/1ps
module can_tx_pick #(
  parameter int NBUF  = 3,
  parameter int ID_W  = 11,
  localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic [NBUF-1:0]      mask,
  input  logic [NBUF*ID_W-1:0] ids,
  input  logic                 by_id,
  output logic [NBUF-1:0]      grant,
  output logic [IDX_W-1:0]     idx
);
  // Does buffer a win against buffer b?
  function automatic logic wins(input logic [ID_W-1:0] ida,
                                input logic [ID_W-1:0] idb,
                                input logic a_lower, input logic mode_id);
    if (mode_id) return (ida < idb) || ((ida == idb) && a_lower);
    return a_lower;
  endfunction

  logic [NBUF*NBUF-1:0] beat;

  for (genvar i = 0; i < NBUF; i++) begin : g_row
    for (genvar j = 0; j < NBUF; j++) begin : g_col
      localparam bit LOWER = (i < j);
      if (i == j) begin : g_self
        assign beat[i*NBUF+j] = 1'b1;
      end else begin : g_pair
        assign beat[i*NBUF+j] = !mask[j] ||
          wins(ids[i*ID_W +: ID_W], ids[j*ID_W +: ID_W], LOWER, by_id);
      end
    end
    assign grant[i] = mask[i] && (&beat[i*NBUF +: NBUF]);
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < NBUF; k++)
      if (grant[k]) idx = k[IDX_W-1:0];
  end

  always_comb begin
    AST_GRANT_ONEHOT: assert (!(|mask) || $onehot(grant)); // R4
  end
endmodule

// File: rtl/can_tx_slots.sv
`timescale 1ns/1ps
module can_tx_slots
  import can_cmd_pkg::*;
#(
  parameter int NBUF  = 3,
  parameter int ID_W  = 11,
  localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_t                 cmd,
  input  logic [NBUF-1:0]      sel,
  input  logic                 by_id,
  input  logic [NBUF*ID_W-1:0] ids,
  input  logic                 tx_busy,
  input  logic                 tx_done,
  output logic                 tx_start,
  output logic [IDX_W-1:0]     tx_slot,
  output logic                 tx_self,
  output logic [NBUF-1:0]      pend,
  output logic                 rx_enable
);
  logic [NBUF-1:0]  flight;
  logic [NBUF-1:0]  self_q;
  logic [NBUF-1:0]  req_grant;
  logic [NBUF-1:0]  go_grant;
  logic [IDX_W-1:0] req_idx;
  logic             queue_cmd;
  logic             abort_hit;

  assign queue_cmd = cmd.tx || cmd.self_rx;
  assign abort_hit = cmd.abt && |(sel & flight);

  can_tx_pick #(.NBUF(NBUF), .ID_W(ID_W)) u_req_pick (
    .mask(sel), .ids(ids), .by_id(by_id), .grant(req_grant), .idx(req_idx));

  can_tx_pick #(.NBUF(NBUF), .ID_W(ID_W)) u_go_pick (
    .mask(pend), .ids(ids), .by_id(by_id), .grant(go_grant), .idx(tx_slot));

  assign tx_start  = !tx_busy && !(|flight) && (|pend);
  assign tx_self   = |(go_grant & self_q);
  assign rx_enable = !(|(flight & ~self_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      flight <= '0;
      self_q <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (tx_done && flight[i]) begin
          pend[i]   <= 1'b0;
          flight[i] <= 1'b0;
        end else if (tx_start && go_grant[i]) begin
          flight[i] <= 1'b1;
        end
        if (cmd.abt && sel[i] && !flight[i]) pend[i] <= 1'b0;
        if (queue_cmd && req_grant[i]) begin
          pend[i]   <= 1'b1;
          self_q[i] <= cmd.self_rx;
        end
      end
    end
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flight)); // R6
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R6
  AST_ABORT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit && !tx_done |=> |(pend & $past(sel & flight))); // R7
  AST_PLAIN_MUTES_RX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start && !tx_self && !queue_cmd |=> !rx_enable); // R8
  AST_SELF_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start && tx_self && !queue_cmd |=> rx_enable); // R8
endmodule

// File: rtl/can_rx_status.sv
`timescale 1ns/1ps
module can_rx_status #(
  parameter int RX_DEPTH = 2,
  localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_in,
  input  logic release_cmd,
  input  logic clear_cmd,
  output logic full_flag,
  output logic overrun
);
  logic [CNT_W-1:0] held;
  logic             rel_eff;
  logic             at_cap;
  logic             lost;

  assign rel_eff   = release_cmd && (held != '0);
  assign at_cap    = (held == CNT_W'(RX_DEPTH));
  assign lost      = frame_in && at_cap && !rel_eff;
  assign full_flag = (held != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= '0;
      overrun <= 1'b0;
    end else begin
      if (frame_in && !lost && !rel_eff)      held <= held + 1'b1;
      else if (rel_eff && !frame_in)          held <= held - 1'b1;
      if (lost)           overrun <= 1'b1;
      else if (clear_cmd) overrun <= 1'b0;
    end
  end

  AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_in && at_cap && !release_cmd |=> overrun); // R10
  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    release_cmd && !frame_in && (held == CNT_W'(1)) |=> !full_flag); // R9
  AST_CLEAR_DOR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_cmd && !frame_in |=> !overrun); // R11
endmodule

// File: rtl/can_cmd_ctrl.sv
`timescale 1ns/1ps
module can_cmd_ctrl
  import can_cmd_pkg::*;
#(
  parameter int NBUF     = 3,
  parameter int ID_W     = 11,
  parameter int RX_DEPTH = 2,
  localparam int CMD_W   = SEL_LSB + NBUF,
  localparam int IDX_W   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [CMD_W-1:0]     reg_wdata,
  output logic [CMD_W-1:0]     reg_rdata,
  input  logic                 prio_by_id,
  input  logic [NBUF*ID_W-1:0] slot_id,
  input  logic                 tx_busy,
  input  logic                 tx_done,
  output logic                 tx_start,
  output logic [IDX_W-1:0]     tx_slot,
  output logic                 tx_self,
  output logic [NBUF-1:0]      tx_pend,
  output logic                 rx_enable,
  input  logic                 rx_frame,
  output logic                 rx_full_flag,
  output logic                 rx_overrun,
  output logic                 cmd_err
);
  cmd_t            cmd;
  logic [NBUF-1:0] sel;

  assign reg_rdata = '0;

  can_cmd_decode #(.NBUF(NBUF)) u_decode (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .cmd(cmd), .sel(sel), .err(cmd_err));

  can_tx_slots #(.NBUF(NBUF), .ID_W(ID_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .sel(sel), .by_id(prio_by_id),
    .ids(slot_id), .tx_busy(tx_busy), .tx_done(tx_done),
    .tx_start(tx_start), .tx_slot(tx_slot), .tx_self(tx_self),
    .pend(tx_pend), .rx_enable(rx_enable));

  can_rx_status #(.RX_DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_in(rx_frame),
    .release_cmd(cmd.rel), .clear_cmd(cmd.clr),
    .full_flag(rx_full_flag), .overrun(rx_overrun));

  AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata == '0); // R1
endmodule

// File: tb/can_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module can_cmd_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        prio_by_id = 1'b0;
  logic [32:0] slot_id = '0;
  logic        tx_busy = 1'b1;
  logic        tx_done = 1'b0;
  logic        tx_start;
  logic [1:0]  tx_slot;
  logic        tx_self;
  logic [2:0]  tx_pend;
  logic        rx_enable;
  logic        rx_frame = 1'b0;
  logic        rx_full_flag;
  logic        rx_overrun;
  logic        cmd_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct { int slot; bit self_rx; } launch_t;
  launch_t exp_q[$];

  always #2.5 clk = ~clk;

  can_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .prio_by_id(prio_by_id), .slot_id(slot_id),
    .tx_busy(tx_busy), .tx_done(tx_done), .tx_start(tx_start),
    .tx_slot(tx_slot), .tx_self(tx_self), .tx_pend(tx_pend),
    .rx_enable(rx_enable), .rx_frame(rx_frame), .rx_full_flag(rx_full_flag),
    .rx_overrun(rx_overrun), .cmd_err(cmd_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic frame();
    @(negedge clk); rx_frame = 1'b1;
    @(negedge clk); rx_frame = 1'b0;
  endtask

  task automatic expect_launch(input int slot, input bit self_rx);
    launch_t e;
    e.slot = slot; e.self_rx = self_rx;
    exp_q.push_back(e);
  endtask

  task automatic finish_flight();
    @(negedge clk); tx_done = 1'b1; tx_busy = 1'b0;
    @(negedge clk); tx_done = 1'b0;
  endtask

  // Monitor: pops the expected launch for every tx_start pulse
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_start) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected launch slot=%0d expected=none", tx_slot);
      end else begin
        launch_t e;
        e = exp_q.pop_front();
        check("R6 launch slot", 32'(tx_slot), 32'(e.slot));
        check("R8 launch self flag", 32'(tx_self), 32'(e.self_rx));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", 32'(reg_rdata), 0);
    check("R1 pend", 32'(tx_pend), 0);
    check("R1 flags", {rx_full_flag, rx_overrun, cmd_err, tx_start}, 0);
    check("R1 rx_enable", 32'(rx_enable), 1);

    // R4 local priority: all three selected -> buffer 0
    wr_cmd(8'hE1);
    check("R4 lowest buffer", 32'(tx_pend), 32'b001);
    check("R1 rdata after write", 32'(reg_rdata), 0);
    wr_cmd(8'hE2);
    check("R7 abort idle buffers", 32'(tx_pend), 0);

    // R5 identifier priority: id0=9, id1=3, id2=5 -> buffer 1
    prio_by_id = 1'b1;
    slot_id = {11'd5, 11'd3, 11'd9};
    wr_cmd(8'hE1);
    check("R5 lowest id", 32'(tx_pend), 32'b010);
    wr_cmd(8'hE2);
    // R5 tie: id0=id1=4, id2=1 but not selected -> buffer 0
    slot_id = {11'd1, 11'd4, 11'd4};
    wr_cmd(8'h61);
    check("R5 tie to lower buffer", 32'(tx_pend), 32'b001);
    wr_cmd(8'hE2);

    // R3 no select bits
    wr_cmd(8'h01);
    check("R3 no select no effect", 32'(tx_pend), 0);

    // R2 back-to-back write dropped
    prio_by_id = 1'b0;
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h21;
    @(negedge clk); reg_wdata = 8'h41;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    check("R2 second write dropped", 32'(tx_pend), 32'b001);
    check("R2 error flag", 32'(cmd_err), 1);

    // R6/R7/R8 launch sequence
    wr_cmd(8'h81);
    check("R3 buffer 2 queued", 32'(tx_pend), 32'b101);
    expect_launch(0, 1'b0);
    @(negedge clk); tx_busy = 1'b0;
    @(negedge clk); tx_busy = 1'b1;
    check("R8 plain tx mutes receiver", 32'(rx_enable), 0);
    wr_cmd(8'h22);
    check("R7 in-flight abort refused", 32'(tx_pend), 32'b101);
    check("R2 error still sticky", 32'(cmd_err), 1);
    expect_launch(2, 1'b0);
    finish_flight();
    check("R6 done clears pending", 32'(tx_pend), 32'b100);
    @(negedge clk); tx_busy = 1'b1;
    finish_flight();
    check("R6 second done", 32'(tx_pend), 0);
    tx_busy = 1'b1;

    // R8 self reception
    wr_cmd(8'h30);
    check("R8 self request queued", 32'(tx_pend), 32'b001);
    expect_launch(0, 1'b1);
    @(negedge clk); tx_busy = 1'b0;
    @(negedge clk); tx_busy = 1'b1;
    check("R8 self keeps receiver", 32'(rx_enable), 1);
    finish_flight();
    tx_busy = 1'b1;
    check("R6 queue drained", exp_q.size(), 0);

    // R9/R10/R11 receive side
    wr_cmd(8'h04);
    check("R9 release when empty", 32'(rx_full_flag), 0);
    frame();
    check("R9 frame held", 32'(rx_full_flag), 1);
    frame();
    frame();
    check("R10 overrun on full", 32'(rx_overrun), 1);
    wr_cmd(8'h04);
    check("R9 one frame left", 32'(rx_full_flag), 1);
    wr_cmd(8'h04);
    check("R9 last release clears", 32'(rx_full_flag), 0);
    wr_cmd(8'h08);
    check("R11 clear overrun", 32'(rx_overrun), 0);

    // Same-cycle release and arrival on a full store
    frame();
    frame();
    @(negedge clk); rx_frame = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h04;
    @(negedge clk); rx_frame = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    check("R10 release admits frame", 32'(rx_overrun), 0);
    // Same-cycle clear and overrun
    @(negedge clk); rx_frame = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h08;
    @(negedge clk); rx_frame = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    check("R11 overrun beats clear", 32'(rx_overrun), 1);
    wr_cmd(8'h04);
    check("R9 store held two", 32'(rx_full_flag), 1);
    wr_cmd(8'h04);
    check("R9 store empty", 32'(rx_full_flag), 0);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule